// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block runs an asynchronous static RAM from a synchronous clock domain. The memory side has an 8-bit shared bidirectional data bus, a registered address, and three active-low strobes: chip select, write enable and output enable. The user side offers one request at a time. A request carries a read/write flag, an address and, for writes, a data byte.

The request port is valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole of a memory cycle. While it is low, the request fields are not sampled, and a requester holding `req_valid` simply waits.

The response side has no back-pressure. Read data appears on `rd_data` with a one-cycle `rd_valid` pulse, and the user must take it in that cycle.

The enable that drives the data bus is a separate flop. It is not a decode of the strobes. It stays on for one clock after write enable rises, so the memory sees stable data across its write-end edge. Read data is captured straight from the bus. The strobe timing guarantees the bus is settled at the capture edge, so no synchronizer is used.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset all three strobes are high (1), the bus is released, `busy` is 0, `req_ready` is 1 and `rd_valid` is 0.
- R2: A write (`req_we`=1) takes three busy clocks after acceptance. Chip select is low and output enable is high in all three clocks. Write enable is high, then low, then high.
- R3: During all three write clocks, the controller drives the accepted write byte on the data bus. The byte is still present when write enable rises. The memory thus stores the accepted byte.
- R4: A read (`req_we`=0) holds chip select and output enable low, and write enable high, for two clocks after acceptance.
- R5: In the clock after the second read clock, output enable is high again and `rd_valid` is 1 for exactly one clock. In that clock `rd_data` equals the memory byte at the requested address.
- R6: `busy` is 1 and `req_ready` is 0 from the clock after acceptance until the cycle ends. A request presented while busy is not performed and does not alter memory.
- R7: `mem_addr` stays at the accepted address for the whole cycle.
- R8: The controller never drives the data bus while output enable is low.
- R9: Back-to-back requests are allowed. A new request may be accepted in the first idle clock, including the clock that carries `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Request address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Memory cycle in progress |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 8 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | inout | 8 | Shared data bus |

## Verification
The hardest case to reach from the ports is a request that arrives while the controller is busy. The bench keeps `req_valid` high with a different address and byte through the first write clocks. It then drops `req_valid` before the first idle edge and reads back the competing address to show it was untouched.

Hold of write data is checked inside the bench memory model. The model samples the bus at the instant write enable rises, and that byte is compared with the written value.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WSET  = 3'd1,
    ST_WPUL  = 3'd2,
    ST_WHLD  = 3'd3,
    ST_ROE1  = 3'd4,
    ST_ROE2  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_we,
  output logic req_ready,
  output logic busy,
  output logic accept,
  output logic drv_set,
  output logic drv_clr,
  output logic cap_en,
  output logic cs_n,
  output logic we_n,
  output logic oe_n,
  output logic rd_valid
);
  seq_state_t st_q, st_d;

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;
  assign drv_set   = accept && req_we;
  assign drv_clr   = (st_q == ST_WHLD);
  assign cap_en    = (st_q == ST_ROE2);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) st_d = req_we ? ST_WSET : ST_ROE1;
      ST_WSET: st_d = ST_WPUL;
      ST_WPUL: st_d = ST_WHLD;
      ST_WHLD: st_d = ST_IDLE;
      ST_ROE1: st_d = ST_ROE2;
      ST_ROE2: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cs_n     <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      rd_valid <= 1'b0;
    end else begin
      st_q     <= st_d;
      cs_n     <= (st_d == ST_IDLE);
      we_n     <= (st_d != ST_WPUL);
      oe_n     <= !((st_d == ST_ROE1) || (st_d == ST_ROE2));
      rd_valid <= cap_en;
    end
  end

  assert_rdv_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_oe_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |=> !oe_n);
  assert_we_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && oe_n));
endmodule

// File: rtl/sram_io.sv
module sram_io #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              drv_set,
  input  logic              drv_clr,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (accept) begin
        mem_addr <= addr_in;
        dq_out   <= wdata_in;
      end
      if (drv_set)      dq_oe <= 1'b1;
      else if (drv_clr) dq_oe <= 1'b0;
      if (cap_en) rd_data <= dq_in;
    end
  end

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq
);
  logic              accept, drv_set, drv_clr, cap_en, dq_oe;
  logic [DATA_W-1:0] dq_out;

  sram_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_ready(req_ready), .busy(busy), .accept(accept),
    .drv_set(drv_set), .drv_clr(drv_clr), .cap_en(cap_en),
    .cs_n(mem_cs_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .rd_valid(rd_valid)
  );

  sram_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk(clk), .rst_n(rst_n), .accept(accept), .drv_set(drv_set),
    .drv_clr(drv_clr), .cap_en(cap_en), .addr_in(req_addr),
    .wdata_in(req_wdata), .dq_in(mem_dq), .busy(busy),
    .mem_addr(mem_addr), .dq_out(dq_out), .dq_oe(dq_oe), .rd_data(rd_data)
  );

  assign mem_dq = dq_oe ? dq_out : {DATA_W{1'bz}};

  assert_no_fight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> mem_oe_n);
  assert_hold_after_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> dq_oe);
endmodule

// File: tb/sram_bus_ctrl_tb_top.sv
module sram_bus_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_we = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       req_ready, busy, rd_valid, cs_n, we_n, oe_n;
  logic [7:0] rd_data, mem_addr;
  wire  [7:0] dq;
  logic [7:0] mem [256];
  logic [7:0] we_rise_sample;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sram_bus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(cs_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_dq(dq)
  );

  assign dq = (!cs_n && !oe_n && we_n) ? mem[mem_addr] : 8'hzz;

  always @(posedge we_n) begin
    if (!cs_n) begin
      we_rise_sample = dq;
      mem[mem_addr] = dq;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobes(input string tag, input bit c, input bit w, input bit o);
    chk(cs_n == c && we_n == w && oe_n == o, tag,
        {29'd0, cs_n, we_n, oe_n}, {29'd0, c, w, o});
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    chk(req_ready, "R9 ready before write", req_ready, 1);
    req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0;
    strobes("R2 write clk1", 0, 1, 1);
    chk(dq == d, "R3 bus clk1", dq, d);
    chk(busy && !req_ready, "R6 busy in write", busy, 1);
    @(negedge clk);
    strobes("R2 write clk2", 0, 0, 1);
    chk(mem_addr == a, "R7 addr held", mem_addr, a);
    @(negedge clk);
    strobes("R2 write clk3", 0, 1, 1);
    chk(dq == d, "R3 bus clk3", dq, d);
    chk(we_rise_sample == d, "R3 hold at we rise", we_rise_sample, d);
    @(negedge clk);
    strobes("R2 idle after write", 1, 1, 1);
    chk(!busy, "R6 busy cleared", busy, 0);
    chk(mem[a] == d, "R3 memory stored", mem[a], d);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] e, input bit sync);
    if (sync) @(negedge clk);
    req_valid = 1; req_we = 0; req_addr = a;
    @(negedge clk); req_valid = 0;
    strobes("R4 read clk1", 0, 1, 0);
    chk(!rd_valid, "R5 no early valid", rd_valid, 0);
    @(negedge clk);
    strobes("R4 read clk2", 0, 1, 0);
    chk(mem_addr == a, "R7 addr held read", mem_addr, a);
    @(negedge clk);
    chk(oe_n && rd_valid, "R5 valid pulse", {oe_n, rd_valid}, 3);
    chk(rd_data == e, "R5 read data", rd_data, e);
  endtask

  task automatic t_reset;
    chk(cs_n && we_n && oe_n, "R1 strobes", {cs_n, we_n, oe_n}, 7);
    chk(!busy && req_ready && !rd_valid, "R1 idle", {busy, req_ready, rd_valid}, 2);
  endtask

  task automatic t_ignore;
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = 8'h10; req_wdata = 8'hC3;
    @(negedge clk);
    req_addr = 8'h20; req_wdata = 8'h99;
    chk(!req_ready, "R6 not ready", req_ready, 0);
    @(negedge clk);
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    chk(!busy, "R6 single cycle only", busy, 0);
    chk(mem[8'h10] == 8'hC3 && mem[8'h20] == (8'h20 ^ 8'h5A),
        "R6 busy request ignored", mem[8'h20], 8'h20 ^ 8'h5A);
    do_read(8'h20, 8'h20 ^ 8'h5A, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = i[7:0] ^ 8'h5A;
    we_rise_sample = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    do_read(8'h33, 8'h33 ^ 8'h5A, 1);
    @(negedge clk);
    chk(!rd_valid, "R5 pulse one clock", rd_valid, 0);
    do_write(8'h00, 8'hFF);
    do_write(8'hFF, 8'h00);
    do_write(8'h7E, 8'hA5);
    do_read(8'h00, 8'hFF, 1);
    do_read(8'hFF, 8'h00, 0);
    do_read(8'h7E, 8'hA5, 0);
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule